// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Block

This block collects the interrupt events of an I2C controller. There are twelve sources. Ten of them are edge-type events that arrive as single-cycle pulses. Each pulse sets a sticky bit in the raw status word. The other two are level conditions taken from FIFO fill levels: the receive FIFO holding more entries than its threshold, and the transmit FIFO holding no more entries than its threshold. The block also keeps a mask and produces a masked status word equal to raw AND mask. It drives one interrupt line, which is the registered OR of the masked word.

Software clears sticky sources by reading dedicated addresses. Each sticky source has its own clear address, so one source can be acknowledged without touching another that fired after the status read. A single combined address clears every sticky source at once. A transmit-abort event also records a cause vector in an abort-cause register. Clearing the abort source, by its own address or by the combined one, wipes that cause register in the same cycle.

Access is a simple register port with read and write strobes and an 8-bit byte address. Read data is registered.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset the sticky status bits are 0, the abort-cause register is 0, both thresholds are 0, `irq` is 0, and the mask reads 0x254 (bits 2, 4, 6 and 9 set).
- R2: Status bit positions are fixed: 0 rx underflow, 1 rx overflow, 2 rx level, 3 tx overflow, 4 tx level, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt_pulse[k]` for a sticky bit k sets raw bit k at the next edge. The bit holds until it is cleared. The raw word is read at 0x34.
- R3: The mask is read/write at 0x30 (bits 11:0). The masked word at 0x2C reads as raw AND mask.
- R4: A read of one of the ten per-source clear addresses clears only that source. The addresses are 0x44, 0x48, 0x4C, 0x50, 0x54, 0x58, 0x5C, 0x60, 0x64 and 0x68, for bits 0, 1, 3, 5, 6, 7, 8, 9, 10 and 11 in that order. The read returns the pre-clear value of the bit in data bit 0.
- R5: A read of 0x40 clears all ten sticky bits and returns 0.
- R6: A pulse on bit 6 ORs `abort_cause` into the abort-cause register, read at 0x80. A read of 0x54 or 0x40 clears that register.
- R7: Bit 2 is 1 while `rx_level` > rx threshold (written at 0x38). Bit 4 is 1 while `tx_level` <= tx threshold (written at 0x3C). Clear reads have no effect on either bit.
- R8: If a source's event arrives in the same cycle as a read that clears it, the bit stays set. For bit 6 the abort-cause register then holds exactly the new cause.
- R9: `irq` is the OR of the masked word, delayed by one register stage.
- R10: `reg_rdata` loads only on a read, with the value the register had before that edge. Unmapped addresses read 0. Writes to read-only or unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe (read side effects take place at this edge) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_pulse | input | 12 | Event pulses, one per status bit (bits 2 and 4 are not used) |
| abort_cause | input | CAUSE_W | Abort cause vector, sampled with `evt_pulse[6]` |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
A new event and the clear of that same source can fall in the same cycle, and this is the behaviour most prone to error. The bench provokes the collision by driving a stop-seen pulse during the read of the stop-seen clear address. It then reads the raw word and expects the bit still set. It repeats the collision on the abort source, giving a fresh cause during the abort clear read, and expects the cause register to hold only the new cause. The combined clear is also issued while the receive level condition is true, and the bench expects that level bit to survive.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int NUM_SRC       = 12;
  localparam int NUM_CLR_SLOTS = 10;

  // status bit positions (software decodes these)
  localparam int IRQ_RX_UNDER  = 0;
  localparam int IRQ_RX_OVER   = 1;
  localparam int IRQ_RX_FULL   = 2;
  localparam int IRQ_TX_OVER   = 3;
  localparam int IRQ_TX_EMPTY  = 4;
  localparam int IRQ_RD_REQ    = 5;
  localparam int IRQ_TX_ABRT   = 6;
  localparam int IRQ_RX_DONE   = 7;
  localparam int IRQ_ACTIVITY  = 8;
  localparam int IRQ_STOP_SEEN = 9;
  localparam int IRQ_STRT_SEEN = 10;
  localparam int IRQ_GEN_CALL  = 11;

  localparam logic [NUM_SRC-1:0] LEVEL_MASK   = 12'h014;
  localparam logic [NUM_SRC-1:0] STICKY_MASK  = ~LEVEL_MASK;
  localparam logic [NUM_SRC-1:0] DEFAULT_MASK = 12'h254;

  // register offsets
  localparam logic [7:0] OFF_MASKED     = 8'h2C;
  localparam logic [7:0] OFF_MASK       = 8'h30;
  localparam logic [7:0] OFF_RAW        = 8'h34;
  localparam logic [7:0] OFF_RX_THR     = 8'h38;
  localparam logic [7:0] OFF_TX_THR     = 8'h3C;
  localparam logic [7:0] OFF_CLR_ALL    = 8'h40;
  localparam logic [7:0] OFF_CLR_FIRST  = 8'h44;
  localparam logic [7:0] OFF_ABRT_CAUSE = 8'h80;

  // clear slot n (address OFF_CLR_FIRST + 4n) -> status bit; level bits 2 and 4 are skipped
  function automatic int slot_to_bit(input int slot);
    if (slot < 2)       return slot;
    else if (slot == 2) return 3;
    else                return slot + 2;
  endfunction

  // one-hot (or zero) vector of the sticky bit that a per-source clear address names
  function automatic logic [NUM_SRC-1:0] clear_vec_of(input logic [7:0] addr);
    logic [NUM_SRC-1:0] v;
    v = '0;
    for (int s = 0; s < NUM_CLR_SLOTS; s++) begin
      if (addr == OFF_CLR_FIRST + 8'(4 * s)) v[slot_to_bit(s)] = 1'b1;
    end
    return v;
  endfunction

  // sticky update: a new event wins over a clear in the same cycle
  function automatic logic [NUM_SRC-1:0] sticky_next(input logic [NUM_SRC-1:0] cur,
                                                     input logic [NUM_SRC-1:0] set,
                                                     input logic [NUM_SRC-1:0] clr);
    return ((cur & ~clr) | set) & STICKY_MASK;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [LVL_W-1:0]   rx_thr_o,
  output logic [LVL_W-1:0]   tx_thr_o
);

  logic wr_mask, wr_rx, wr_tx;
  assign wr_mask = wr_en && (addr == OFF_MASK);
  assign wr_rx   = wr_en && (addr == OFF_RX_THR);
  assign wr_tx   = wr_en && (addr == OFF_TX_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= DEFAULT_MASK;
      rx_thr_o <= '0;
      tx_thr_o <= '0;
    end else begin
      if (wr_mask) mask_o   <= wdata;
      if (wr_rx)   rx_thr_o <= wdata[LVL_W-1:0];
      if (wr_tx)   tx_thr_o <= wdata[LVL_W-1:0];
    end
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MASK) |=> (mask_o == $past(wdata))); // R3

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_o) && $stable(rx_thr_o) && $stable(tx_thr_o))); // R10

endmodule

// File: rtl/irq_level_cond.sv
module irq_level_cond
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_thr,
  input  logic [LVL_W-1:0]   tx_thr,
  output logic [NUM_SRC-1:0] level_o
);

  function automatic logic rx_above(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] thr);
    return lvl > thr;
  endfunction

  function automatic logic tx_at_or_below(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] thr);
    return lvl <= thr;
  endfunction

  always_comb begin
    level_o               = '0;
    level_o[IRQ_RX_FULL]  = rx_above(rx_level, rx_thr);
    level_o[IRQ_TX_EMPTY] = tx_at_or_below(tx_level, tx_thr);
  end

  always_comb begin
    AST_LEVEL_ONLY: assert ((level_o & STICKY_MASK) == '0); // R7
  end

endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] masked_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] sticky_q;
  logic               any_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_next(sticky_q, set_i, clr_i);
  end

  assign raw_o      = sticky_q | level_i;
  assign masked_o   = raw_o & mask_i;
  assign any_masked = |masked_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_masked;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (STICKY_MASK[k]) begin : g_sticky
      AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && !set_i[k]) |=> !raw_o[k]); // R4
      AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k] |=> raw_o[k]); // R8
      AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[k] && !clr_i[k]) |=> $stable(raw_o[k])); // R2
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o != '0) |=> irq_o); // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o == '0) |=> !irq_o); // R9

endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause #(
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_i,
  output logic [CAUSE_W-1:0] cause_o
);

  function automatic logic [CAUSE_W-1:0] cause_next(input logic [CAUSE_W-1:0] cur,
                                                    input logic                cap,
                                                    input logic [CAUSE_W-1:0] nc,
                                                    input logic                clr);
    return (clr ? '0 : cur) | (cap ? nc : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_o <= '0;
    else        cause_o <= cause_next(cause_o, capture_i, cause_i, clr_i);
  end

  AST_CAUSE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !capture_i) |=> (cause_o == '0)); // R6
  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> ((cause_o & $past(cause_i)) == $past(cause_i))); // R8

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W   = 6,
  parameter int CAUSE_W = 13,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [CAUSE_W-1:0] abort_cause,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_level,
  output logic               irq
);

  logic [NUM_SRC-1:0] mask, raw, masked, level, clr_sel, clr_vec, set_vec;
  logic [LVL_W-1:0]   rx_thr, tx_thr;
  logic [CAUSE_W-1:0] cause;
  logic [DATA_W-1:0]  rd_next;
  logic               hit_clr_all;

  irq_cfg_regs #(.LVL_W(LVL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mask_o(mask), .rx_thr_o(rx_thr), .tx_thr_o(tx_thr)
  );

  irq_level_cond #(.LVL_W(LVL_W)) u_lvl (
    .rx_level(rx_level), .tx_level(tx_level), .rx_thr(rx_thr), .tx_thr(tx_thr),
    .level_o(level)
  );

  // read side effects: per-source clear plus combined clear
  assign clr_sel     = clear_vec_of(reg_addr);
  assign hit_clr_all = (reg_addr == OFF_CLR_ALL);
  assign clr_vec     = reg_rd ? (clr_sel | (hit_clr_all ? STICKY_MASK : {NUM_SRC{1'b0}}))
                              : {NUM_SRC{1'b0}};
  assign set_vec     = evt_pulse & STICKY_MASK;

  irq_status_bits u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .level_i(level),
    .mask_i(mask), .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  irq_abort_cause #(.CAUSE_W(CAUSE_W)) u_abrt (
    .clk(clk), .rst_n(rst_n), .capture_i(evt_pulse[IRQ_TX_ABRT]), .cause_i(abort_cause),
    .clr_i(clr_vec[IRQ_TX_ABRT]), .cause_o(cause)
  );

  always_comb begin
    case (reg_addr)
      OFF_MASKED:     rd_next = DATA_W'(masked);
      OFF_MASK:       rd_next = DATA_W'(mask);
      OFF_RAW:        rd_next = DATA_W'(raw);
      OFF_RX_THR:     rd_next = DATA_W'(rx_thr);
      OFF_TX_THR:     rd_next = DATA_W'(tx_thr);
      OFF_ABRT_CAUSE: rd_next = DATA_W'(cause);
      default:        rd_next = DATA_W'(|(raw & clr_sel));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CLR_ALL) |=> ((raw & STICKY_MASK & ~$past(evt_pulse)) == '0)); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R10

  AST_ABORT_WITH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CLR_FIRST + 8'h10 && !evt_pulse[IRQ_TX_ABRT])
      |=> (cause == '0 && !raw[IRQ_TX_ABRT])); // R6

endmodule

// File: tb/sim_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_irq_ctrl;
  localparam int LVL_W = 6, CAUSE_W = 13, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [11:0] evt_pulse = '0;
  logic [CAUSE_W-1:0] abort_cause = '0;
  logic [LVL_W-1:0] rx_level = '0, tx_level = 6'd3;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_irq_ctrl #(.LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .abort_cause(abort_cause), .rx_level(rx_level), .tx_level(tx_level), .irq(irq)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  item_t mon_it;
  logic  rd_d;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_d <= 1'b0; else rd_d <= reg_rd;

  // monitor: one read result per read strobe, compared in the cycle after it
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected read data actual=0x%0h expected=none", reg_rdata);
      end else begin
        mon_it = exp_q.pop_front();
        chk(mon_it.tag, reg_rdata, mon_it.exp);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_evt(input logic [7:0] a, input logic [31:0] e, input string tag,
                        input logic [11:0] ev, input logic [CAUSE_W-1:0] c);
    item_t it;
    it.exp = e; it.tag = tag; exp_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a; evt_pulse = ev; abort_cause = c;
    @(negedge clk);
    reg_rd = 1'b0; evt_pulse = '0; abort_cause = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_evt(a, e, tag, 12'h000, '0);
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [CAUSE_W-1:0] c);
    evt_pulse = ev; abort_cause = c; @(negedge clk); evt_pulse = '0; abort_cause = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 irq after reset", 32'(irq), 0);
    rd(8'h34, 32'h000, "R1 raw after reset");
    rd(8'h30, 32'h254, "R1 default mask");
    rd(8'h80, 32'h000, "R1 abort cause after reset");
    rd(8'h38, 32'h000, "R1 rx threshold after reset");

    pulse(12'h00B, '0);
    rd(8'h34, 32'h00B, "R2 raw after pulses on bits 0,1,3");
    rd(8'h2C, 32'h000, "R3 masked under default mask");
    chk("R9 irq low with nothing unmasked", 32'(irq), 0);

    wr(8'h30, 12'hFFF);
    tick();
    chk("R9 irq after unmasking", 32'(irq), 1);
    rd(8'h30, 32'hFFF, "R3 mask readback");
    rd(8'h2C, 32'h00B, "R3 masked with full mask");

    rd(8'h48, 32'h1, "R4 clear read of rx overflow returns prior bit");
    rd(8'h34, 32'h009, "R4 only rx overflow cleared");
    rd(8'h48, 32'h0, "R4 second clear read returns 0");

    pulse(12'hFEB, 13'h0009);
    rd(8'h80, 32'h0009, "R6 abort cause captured");
    pulse(12'h040, 13'h1000);
    rd(8'h80, 32'h1009, "R6 abort cause accumulates");
    rd(8'h54, 32'h1, "R4 abort clear read returns prior bit");
    rd(8'h80, 32'h0000, "R6 abort clear wipes cause");
    rd(8'h34, 32'hFAB, "R4 abort clear leaves other bits");

    rd_evt(8'h60, 32'h1, "R8 stop clear read data", 12'h200, '0);
    rd(8'h34, 32'hFAB, "R8 stop bit survives same-cycle event");
    pulse(12'h040, 13'h0001);
    rd_evt(8'h54, 32'h1, "R8 abort clear read data", 12'h040, 13'h0002);
    rd(8'h80, 32'h0002, "R8 cause holds only new value");
    rd(8'h34, 32'hFEB, "R8 abort bit survives same-cycle event");

    rd(8'h40, 32'h0, "R5 combined clear returns 0");
    rd(8'h34, 32'h000, "R5 all sticky bits cleared");
    rd(8'h80, 32'h000, "R6 combined clear wipes cause");
    chk("R9 irq drops after clear", 32'(irq), 0);

    wr(8'h38, 12'd2);
    rx_level = 6'd3;
    rd(8'h34, 32'h004, "R7 rx level above threshold");
    rd(8'h40, 32'h0, "R7 combined clear during level");
    rd(8'h34, 32'h004, "R7 level bit not cleared by clear read");
    rx_level = 6'd2;
    rd(8'h34, 32'h000, "R7 rx level equal to threshold");
    wr(8'h3C, 12'd5);
    tx_level = 6'd5;
    rd(8'h34, 32'h010, "R7 tx level at threshold");
    tx_level = 6'd6;
    rd(8'h34, 32'h000, "R7 tx level above threshold");
    rd(8'h3C, 32'h005, "R7 tx threshold readback");

    wr(8'h30, 12'h004);
    tick();
    chk("R9 irq low before level rise", 32'(irq), 0);
    rx_level = 6'd3;
    #1;
    chk("R9 irq not combinational", 32'(irq), 0);
    tick();
    chk("R9 irq one cycle after masked rise", 32'(irq), 1);
    rx_level = 6'd0;
    tick();
    chk("R9 irq one cycle after masked fall", 32'(irq), 0);

    wr(8'h34, 12'hFFF);
    wr(8'h2C, 12'hFFF);
    rd(8'h34, 32'h000, "R10 write to read-only raw ignored");
    rd(8'h30, 32'h004, "R10 write to masked offset ignored");
    rd(8'h0C, 32'h000, "R10 unmapped read returns 0");
    rd(8'h44, 32'h000, "R10 clear read of idle source returns 0");
    tick();
    tick();
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10 reads left unanswered actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule